// File: doc/BRIEF.md
# Bi-phase Line Byte Decoder

This block turns the raw sliced bytes of one bi-phase coded line into data bytes. Every input byte holds four two-bit cells. A cell of `01` carries a one and a cell of `10` carries a zero. A cell of `00` or `11` breaks the coding and is counted as an error. Each input byte gives one nibble. Two input bytes in a row give one output byte. A full line is 26 input bytes and gives 13 output bytes.

The upstream slicer raises `lineStart` at the start of each line and presents bytes with `inValid`. Idle cycles between bytes are allowed. Each output byte comes out with `outValid` one cycle after the clock edge that takes its second input byte. The 13th output byte is flagged by `outLast`. It also carries `outErr`, which is the sticky error summary of the whole line. The decode is done in logic from the cell bits, so no lookup table is used.

Top module: `vpsdec`

## Requirements
- R1: After reset, `outValid`, `outLast` and `outErr` are low, and the decoder is ready to take the first byte of a line.
- R2: Cell decoding: a cell `01` decodes to 1 and a cell `10` decodes to 0. The cell in input bits [1:0] gives nibble bit 3, bits [3:2] give bit 2, bits [5:4] give bit 1 and bits [7:6] give bit 0. For example, 0x55 gives 0xF, 0xAA gives 0x0 and 0x56 gives 0x7.
- R3: The first byte of each input pair gives `outByte[7:4]` and the second byte gives `outByte[3:0]`. `outValid` is high for one cycle, in the cycle after the edge that takes the second byte. No output comes after the first byte of a pair.
- R4: A line gives exactly 13 outputs. `outLast` is high only with the 13th output.
- R5: A cell of `00` or `11` is invalid, and any invalid cell in any of the 26 bytes marks the line bad. An invalid cell still decodes to the value of its lower bit.
- R6: `outErr` is high only together with `outLast`. It then shows whether any byte of the line had an invalid cell. Decoding and output carry on after an error.
- R7: `lineStart` clears the byte count and the line error. A byte presented in the same cycle as `lineStart` is the first byte of the new line, and a half-finished pair is dropped.
- R8: Input bytes after the 26th byte of a line are ignored and give no output until the next `lineStart`.
- R9: A cycle with `inValid` low has no effect on decoding, and the next cycle carries no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| lineStart | input | 1 | Start of a new line; clears the count and the error |
| inValid | input | 1 | `inByte` carries a sliced byte this cycle |
| inByte | input | 8 | Raw byte of four bi-phase cells |
| outValid | output | 1 | `outByte` holds a new decoded byte |
| outByte | output | 8 | Decoded data byte |
| outLast | output | 1 | The current output is the 13th of the line |
| outErr | output | 1 | Line error summary, valid with `outLast` |

## Verification
A wrong pair phase in the counter shows up at once: it swaps nibbles between neighbouring output bytes, or it moves the `outValid` pulse by one input byte, on the very first pair it affects. A wrong count limit makes `outLast` appear on the wrong output, or lets extra bytes through after the line ends, and this is seen within that line. A lost or stuck error bit is hidden until the 13th output of the line, so lines with a single bad byte early in the line and at the very end are used to test it. Sweeping all 256 byte values through the cell decoder exposes any cell decoding, bit order or invalid-cell mistake in the first line that contains the affected value.

// File: rtl/vpsdec_pkg.sv
package vpsdec_pkg;

  // Strobes from the line control to the datapath, one set per cycle.
  typedef struct packed {
    logic accept;    // input byte is part of the current line
    logic takeHigh;  // store the decoded nibble as the upper half
    logic emitByte;  // join the nibbles and present an output byte
    logic lastByte;  // this output closes the line
    logic clearErr;  // a new line begins this cycle
  } vpsStrobes_t;

endpackage

// File: rtl/vpsdec_cell_decode.sv
module vpsdec_cell_decode #(
  parameter int CELLS = 4
) (
  input  logic [2*CELLS-1:0] rawByte,
  output logic [CELLS-1:0]   nibble,
  output logic               anyBad
);

  logic [CELLS-1:0] badCell;

  // The lowest cell maps to the nibble MSB; the value of a cell is its lower bit.
  for (genvar c = 0; c < CELLS; c++) begin : g_cell
    assign nibble[CELLS-1-c] = rawByte[2*c];
    assign badCell[c]        = rawByte[2*c+1] ~^ rawByte[2*c];
  end

  assign anyBad = |badCell;

endmodule

// File: rtl/vpsdec_ctrl.sv
module vpsdec_ctrl
  import vpsdec_pkg::*;
#(
  parameter int OUT_BYTES = 13
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        lineStart,
  input  logic        inValid,
  output vpsStrobes_t strb
);

  localparam int IN_BYTES = 2 * OUT_BYTES;
  localparam int CNT_W    = $clog2(IN_BYTES + 1);
  localparam logic [CNT_W-1:0] IN_LIMIT = CNT_W'(IN_BYTES);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(IN_BYTES - 1);

  logic [CNT_W-1:0] inCnt;
  logic [CNT_W-1:0] effCnt;

  always_comb begin
    effCnt        = lineStart ? '0 : inCnt;
    strb.accept   = inValid && (effCnt < IN_LIMIT);
    strb.takeHigh = strb.accept && !effCnt[0];
    strb.emitByte = strb.accept &&  effCnt[0];
    strb.lastByte = strb.emitByte && (effCnt == LAST_IDX);
    strb.clearErr = lineStart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inCnt <= '0;
    end else if (strb.accept) begin
      inCnt <= effCnt + 1'b1;
    end else begin
      inCnt <= effCnt;
    end
  end

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    inCnt <= IN_LIMIT);

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.takeHigh, strb.emitByte}));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineStart && inValid) |=> (inCnt == CNT_W'(1)));

  // R8
  line_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inCnt == IN_LIMIT && !lineStart) |=> (inCnt == IN_LIMIT));

endmodule

// File: rtl/vpsdec_datapath.sv
module vpsdec_datapath
  import vpsdec_pkg::*;
#(
  parameter int CELLS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2*CELLS-1:0]   inByte,
  input  vpsStrobes_t          strb,
  output logic                 outValid,
  output logic [2*CELLS-1:0]   outByte,
  output logic                 outLast,
  output logic                 outErr
);

  logic [CELLS-1:0] nib;
  logic             nibBad;
  logic [CELLS-1:0] highNib;
  logic             errAcc;

  vpsdec_cell_decode #(.CELLS(CELLS)) cell_i (
    .rawByte (inByte),
    .nibble  (nib),
    .anyBad  (nibBad)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highNib  <= '0;
      errAcc   <= 1'b0;
      outValid <= 1'b0;
      outByte  <= '0;
      outLast  <= 1'b0;
      outErr   <= 1'b0;
    end else begin
      outValid <= strb.emitByte;
      outLast  <= strb.lastByte;
      outErr   <= strb.lastByte && (errAcc || nibBad);
      if (strb.emitByte) outByte <= {highNib, nib};
      if (strb.takeHigh) highNib <= nib;
      if (strb.clearErr)    errAcc <= strb.accept && nibBad;
      else if (strb.accept) errAcc <= errAcc || nibBad;
    end
  end

  // R4
  last_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  // R6
  err_on_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    outErr |-> outLast);

  // R5
  bad_reported_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.lastByte && nibBad) |=> outErr);

endmodule

// File: rtl/vpsdec.sv
module vpsdec #(
  parameter int OUT_BYTES = 13,
  parameter int CELLS     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 lineStart,
  input  logic                 inValid,
  input  logic [2*CELLS-1:0]   inByte,
  output logic                 outValid,
  output logic [2*CELLS-1:0]   outByte,
  output logic                 outLast,
  output logic                 outErr
);

  vpsdec_pkg::vpsStrobes_t strb;

  vpsdec_ctrl #(.OUT_BYTES(OUT_BYTES)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .lineStart (lineStart),
    .inValid   (inValid),
    .strb      (strb)
  );

  vpsdec_datapath #(.CELLS(CELLS)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .inByte   (inByte),
    .strb     (strb),
    .outValid (outValid),
    .outByte  (outByte),
    .outLast  (outLast),
    .outErr   (outErr)
  );

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

endmodule

// File: tb/vpsdec_tb.sv
module vpsdec_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineStart = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inByte = 8'h00;
  logic       outValid, outLast, outErr;
  logic [7:0] outByte;

  int nChecks = 0;
  int nErr = 0;

  // bench model state, built from the requirements
  int   mCnt = 0;
  logic [3:0] mHi = 4'h0;
  logic mErr = 1'b0;
  string byteTag = "R2";
  string errTag  = "R6";

  always #10 clk = ~clk;

  vpsdec dut_i (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .inValid(inValid),
    .inByte(inByte), .outValid(outValid), .outByte(outByte),
    .outLast(outLast), .outErr(outErr)
  );

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R2: cell [1:0] -> nibble bit 3 ... cell [7:6] -> bit 0, value = lower bit
  function automatic logic [3:0] expNib(logic [7:0] b);
    logic [3:0] n;
    for (int c = 0; c < 4; c++) n[3-c] = b[2*c];
    return n;
  endfunction

  // R5: 00 or 11 cell is invalid
  function automatic logic expBad(logic [7:0] b);
    logic bad = 1'b0;
    for (int c = 0; c < 4; c++) if (b[2*c] == b[2*c+1]) bad = 1'b1;
    return bad;
  endfunction

  // 1 -> 01, 0 -> 10
  function automatic logic [7:0] enc(logic [3:0] n);
    logic [7:0] b;
    for (int c = 0; c < 4; c++) b[2*c +: 2] = n[3-c] ? 2'b01 : 2'b10;
    return b;
  endfunction

  task automatic pushByte(logic [7:0] b, logic start);
    logic expV = 1'b0, expL = 1'b0, expE = 1'b0;
    logic [7:0] expB = 8'h00;
    string vTag;
    @(negedge clk);
    inValid = 1'b1; inByte = b; lineStart = start;
    if (start) begin mCnt = 0; mErr = 1'b0; end
    vTag = (mCnt >= 26) ? "R8" : "R3";
    if (mCnt < 26) begin
      mErr = mErr | expBad(b);
      if (mCnt % 2 == 0) mHi = expNib(b);
      else begin
        expV = 1'b1; expB = {mHi, expNib(b)};
        expL = (mCnt == 25); expE = expL & mErr;
      end
      mCnt++;
    end
    @(posedge clk); #5;
    chk(vTag, outValid, expV);
    if (expV) begin
      chk(byteTag, outByte, expB);
      chk("R4", outLast, expL);
      chk(errTag, outErr, expE);
    end
    inValid = 1'b0; lineStart = 1'b0;
  endtask

  task automatic idle(logic start);
    @(negedge clk);
    inValid = 1'b0; lineStart = start; inByte = 8'h3C;
    if (start) begin mCnt = 0; mErr = 1'b0; end
    @(posedge clk); #5;
    chk("R9", outValid, 0);
    lineStart = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    nErr++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", outValid, 0); chk("R1", outLast, 0); chk("R1", outErr, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", outValid, 0);

    // R2/R5 sweep every byte value, back to back, first line without lineStart
    for (int l = 0; l < 10; l++)
      for (int k = 0; k < 26; k++)
        pushByte(8'((l * 26 + k) & 255), (k == 0) && (l != 0));

    // R6 clean lines, with gaps (R9)
    errTag = "R6";
    for (int l = 0; l < 16; l++)
      for (int k = 0; k < 26; k++) begin
        pushByte(enc(4'((l + k) & 15)), k == 0);
        if (l[0] && k[1]) idle(1'b0);
      end

    // R5 single bad byte early, then single bad byte at the very end
    errTag = "R5";
    for (int k = 0; k < 26; k++) pushByte((k == 3) ? 8'h00 : enc(4'(k)), k == 0);
    for (int k = 0; k < 26; k++) pushByte((k == 25) ? 8'hFF : enc(4'(~k)), k == 0);
    for (int k = 0; k < 26; k++) pushByte((k == 12) ? 8'h5D : 8'h56, k == 0);

    // R8 extra bytes after a full line
    for (int k = 0; k < 3; k++) pushByte(enc(4'hA), 1'b0);

    // R7 restart mid-line: bad half line, then lineStart mid-pair, clean line
    byteTag = "R7"; errTag = "R7";
    for (int k = 0; k < 9; k++) pushByte((k == 2) ? 8'h0F : enc(4'(k)), k == 0);
    for (int k = 0; k < 26; k++) pushByte(enc(4'(3 * k)), k == 0);
    // lineStart alone on an idle cycle, then a clean line
    for (int k = 0; k < 5; k++) pushByte(8'hC3, k == 0);
    idle(1'b1);
    for (int k = 0; k < 26; k++) pushByte(enc(4'(k + 5)), 1'b0);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule